// File: doc/BRIEF.md
# Two-Byte Command Word Assembler

This block sits behind a byte-wide receive FIFO and turns the byte stream into 16-bit command words. Each pair of consecutive bytes forms one word. The earlier byte of the pair fills the low half and carries a servo angle. The later byte fills the high half and carries a servo identifier. A one-cycle valid pulse marks each finished word for the decoder downstream.

The assembler watches the FIFO's empty flag and issues exactly one read strobe for each byte it takes. The FIFO is assumed to present its head byte on the data lines whenever it is not empty, and to pop that byte on the clock edge where the strobe is high. Each byte is written into its half of the output register in place. The word therefore shows a partial value between the two captures, and it is only final in the cycle where the valid pulse is high. A synchronous reset is the only way to recover framing.

Top module: `byte_pair_packer`

## Requirements
- R1: While reset is high at a clock edge, the word is cleared to 0x0000 and the controller returns to idle. After that edge, the read strobe and the valid output are both low.
- R2: In idle, while the FIFO empty flag is high, no read strobe is issued and the word does not change.
- R3: In idle, when empty is low, the read strobe is high in that cycle. At the next edge the head byte is written into word bits 7:0, and bits 15:8 keep their old value.
- R4: In the cycle after a low-byte capture the read strobe is low. The controller then waits, with no strobe and no valid pulse, for as long as empty stays high.
- R5: When empty is low during the wait, the read strobe is high. At the next edge the head byte is written into bits 15:8, and bits 7:0 are kept. For example, 0xC8 followed by 0x01 gives 0x01C8.
- R6: The valid output is high for exactly one cycle: the cycle right after the high-byte read. In that cycle the word already holds its final value. The controller then returns to idle.
- R7: The read strobe is never high while empty is high. Exactly one strobe is issued for each byte consumed, so N words use exactly 2N strobes.
- R8: A reset that arrives partway through a word discards the half-built word, including a reset in the same cycle as the high-byte read. No valid pulse follows it, and the next pair is assembled correctly.
- R9: Between captures, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifoEmpty | input | 1 | FIFO empty flag, high when no byte is waiting |
| fifoData | input | BYTE_W | FIFO head byte, valid while fifoEmpty is low |
| fifoRd | output | 1 | Read strobe: the FIFO pops its head byte at the edge where this is high |
| cmdWord | output | 2*BYTE_W | Assembled word: angle in the low half, identifier in the high half |
| cmdValid | output | 1 | One-cycle pulse that marks a finished word |

## Verification
Two functions can land in the same cycle. A synchronous reset can coincide with the read of a high byte, so the FIFO pops a byte while the word is being cleared. The bench sets this up by loading a full pair and raising reset exactly in the cycle where the second strobe is high. It then expects a cleared word and no valid pulse. Back-to-back pairs with the FIFO already full also put the end of one word next to the first read of the next. The bench judges these by the exact word values and by a count of strobes against bytes consumed.

// File: rtl/pair_pkg.sv
`timescale 1ns/1ps
package pair_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TAKE_LO = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_TAKE_HI = 2'd3
  } pairState_e;

  // Load strobes from control to datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
  } pairStrobe_t;

endpackage

// File: rtl/pair_ctrl.sv
`timescale 1ns/1ps
module pair_ctrl
  import pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        fifoEmpty,
  output logic        rdStrobe,
  output logic        wordValid,
  output pairStrobe_t strobes
);

  pairState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (!fifoEmpty) stateNext = ST_TAKE_LO;
      ST_TAKE_LO: stateNext = ST_WAIT_HI;
      ST_WAIT_HI: if (!fifoEmpty) stateNext = ST_TAKE_HI;
      ST_TAKE_HI: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.loadLo = (state == ST_IDLE)    && !fifoEmpty;
    strobes.loadHi = (state == ST_WAIT_HI) && !fifoEmpty;
  end

  assign rdStrobe  = strobes.loadLo | strobes.loadHi;
  assign wordValid = (state == ST_TAKE_HI);

  AST_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    rdStrobe |-> !fifoEmpty); // R7
  AST_READ_GAP: assert property (@(posedge clk) disable iff (rst)
    rdStrobe |=> !rdStrobe); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid); // R6
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> $past(rdStrobe)); // R6

endmodule

// File: rtl/pair_datapath.sv
`timescale 1ns/1ps
module pair_datapath
  import pair_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  pairStrobe_t           strobes,
  input  logic [BYTE_W-1:0]     byteIn,
  output logic [2*BYTE_W-1:0]   word
);

  localparam int HALVES = 2;

  for (genvar h = 0; h < HALVES; h++) begin : gHalf
    logic loadSel;
    assign loadSel = (h == 0) ? strobes.loadLo : strobes.loadHi;
    always_ff @(posedge clk) begin
      if (rst)          word[h*BYTE_W +: BYTE_W] <= '0;
      else if (loadSel) word[h*BYTE_W +: BYTE_W] <= byteIn;
    end
  end

  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobes.loadLo |=> $stable(word[2*BYTE_W-1:BYTE_W])); // R3
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (rst)
    strobes.loadHi |=> $stable(word[BYTE_W-1:0])); // R5
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
    (!strobes.loadLo && !strobes.loadHi) |=> $stable(word)); // R9

endmodule

// File: rtl/byte_pair_packer.sv
`timescale 1ns/1ps
module byte_pair_packer
  import pair_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifoEmpty,
  input  logic [BYTE_W-1:0]   fifoData,
  output logic                fifoRd,
  output logic [2*BYTE_W-1:0] cmdWord,
  output logic                cmdValid
);

  pairStrobe_t strobes;

  pair_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .fifoEmpty (fifoEmpty),
    .rdStrobe  (fifoRd),
    .wordValid (cmdValid),
    .strobes   (strobes)
  );

  pair_datapath #(.BYTE_W(BYTE_W)) uData (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .byteIn  (fifoData),
    .word    (cmdWord)
  );

  AST_HI_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (fifoRd && cmdWord == cmdWord) |-> 1'b1 ##0 !(cmdValid && fifoRd)); // R6

endmodule

// File: tb/tb_byte_pair_packer.sv
`timescale 1ns/1ps
module tb_byte_pair_packer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifoEmpty;
  logic [7:0]  fifoData;
  logic        fifoRd;
  logic [15:0] cmdWord;
  logic        cmdValid;

  always #2.5 clk = ~clk;

  // Behavioural FIFO: head byte always presented, pop on strobe
  logic [7:0] fifoMem [0:63];
  logic [5:0] wrPtr = '0;
  logic [5:0] rdPtr = '0;
  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoData  = fifoMem[rdPtr];
  always @(posedge clk) if (fifoRd && !fifoEmpty) rdPtr <= rdPtr + 6'd1;

  byte_pair_packer #(.BYTE_W(8)) dut (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .fifoData(fifoData),
    .fifoRd(fifoRd), .cmdWord(cmdWord), .cmdValid(cmdValid)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int strobeCount = 0;
  int logCount = 0;
  logic [15:0] logWord [0:63];

  always @(negedge clk) begin
    cycles++;
    if (fifoRd === 1'b1) begin
      strobeCount++;
      checks++;
      if (fifoEmpty) begin
        errors++;
        $display("FAIL R7: strobe while empty, actual empty=%0b expected 0", fifoEmpty);
      end
    end
    if (cmdValid === 1'b1 && logCount < 64) begin
      logWord[logCount] = cmdWord;
      logCount++;
    end
    if (cycles == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drivePoint();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    fifoMem[wrPtr] = b;
    wrPtr = wrPtr + 6'd1;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) drivePoint();
  endtask

  task automatic testReset();
    drivePoint(); rst = 1'b1;
    waitCycles(2); rst = 1'b0;
    @(negedge clk);
    chk("R1 word", cmdWord, 16'h0000);
    chk("R1 strobe", {15'd0, fifoRd}, 16'h0);
    chk("R1 valid", {15'd0, cmdValid}, 16'h0);
  endtask

  task automatic testIdleEmpty();
    int s0;
    s0 = strobeCount;
    waitCycles(10);
    @(negedge clk);
    chk("R2 no strobe", 16'(strobeCount - s0), 16'd0);
    chk("R2 word", cmdWord, 16'h0000);
  endtask

  task automatic testFirstPair();
    drivePoint();
    push(8'hC8); push(8'h01);
    @(negedge clk);
    chk("R3 strobe in idle", {15'd0, fifoRd}, 16'h1);
    @(negedge clk);
    chk("R3 low captured", cmdWord, 16'h00C8);
    chk("R4 strobe gap", {15'd0, fifoRd}, 16'h0);
    chk("R4 no valid", {15'd0, cmdValid}, 16'h0);
    @(negedge clk);
    chk("R5 strobe in wait", {15'd0, fifoRd}, 16'h1);
    @(negedge clk);
    chk("R6 valid", {15'd0, cmdValid}, 16'h1);
    chk("R5 word", cmdWord, 16'h01C8);
    @(negedge clk);
    chk("R6 single pulse", {15'd0, cmdValid}, 16'h0);
    chk("R9 word held", cmdWord, 16'h01C8);
  endtask

  task automatic testLateSecond();
    int l0, s0;
    l0 = logCount; s0 = strobeCount;
    drivePoint(); push(8'h34);
    waitCycles(8);
    @(negedge clk);
    chk("R3 high kept", cmdWord, 16'h0134);
    chk("R4 waiting no valid", 16'(logCount - l0), 16'd0);
    chk("R4 one strobe", 16'(strobeCount - s0), 16'd1);
    drivePoint(); push(8'h12);
    waitCycles(6);
    @(negedge clk);
    chk("R5 late pair count", 16'(logCount - l0), 16'd1);
    chk("R5 late pair word", logWord[l0], 16'h1234);
  endtask

  task automatic testStream();
    int l0, s0;
    l0 = logCount; s0 = strobeCount;
    drivePoint();
    for (int i = 0; i < 6; i++) begin
      push(8'(8'h10 + i));
      push(8'(8'hA0 + i));
    end
    waitCycles(40);
    @(negedge clk);
    chk("R7 words", 16'(logCount - l0), 16'd6);
    chk("R7 strobes", 16'(strobeCount - s0), 16'd12);
    for (int i = 0; i < 6; i++)
      chk("R5 stream word", logWord[l0 + i], {8'(8'hA0 + i), 8'(8'h10 + i)});
  endtask

  task automatic testResetMidWord();
    int l0;
    drivePoint(); push(8'h77);
    waitCycles(5);
    rst = 1'b1;
    drivePoint(); rst = 1'b0;
    @(negedge clk);
    chk("R8 cleared", cmdWord, 16'h0000);
    l0 = logCount;
    drivePoint(); push(8'hAA); push(8'h55);
    waitCycles(8);
    @(negedge clk);
    chk("R8 realigned count", 16'(logCount - l0), 16'd1);
    chk("R8 realigned word", logWord[l0], 16'h55AA);
  endtask

  task automatic testResetOnHighRead();
    int l0;
    l0 = logCount;
    drivePoint(); push(8'h3C); push(8'hE1);
    drivePoint();
    drivePoint(); rst = 1'b1;
    drivePoint(); rst = 1'b0;
    @(negedge clk);
    chk("R8 collide valid", {15'd0, cmdValid}, 16'h0);
    chk("R8 collide word", cmdWord, 16'h0000);
    waitCycles(4);
    @(negedge clk);
    chk("R8 collide no word", 16'(logCount - l0), 16'd0);
    chk("R8 fifo drained", {15'd0, fifoEmpty}, 16'h1);
  endtask

  initial begin
    testReset();
    testIdleEmpty();
    testFirstPair();
    testLateSecond();
    testStream();
    testResetMidWord();
    testResetOnHighRead();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule